// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Line Router

This block gathers the interrupt conditions of a UART into one raw status word, lets software choose which of them may raise an interrupt, and drives six level-sensitive interrupt lines. Event sources elsewhere in the UART (receive, transmit, receive timeout, modem lines, line errors) each pulse one bit of `evt_set` for a single cycle. The matching raw bit then stays set until software clears it by writing a one to that position of the clear register.

Software reaches the block through a small register port with a word address. One register holds the enable mask. One shows the raw status. One shows the raw status gated by the mask. One is the write-one-to-clear register. A write to the data register address also raises the transmit bit, because handing the UART a character is itself a transmit event. Reads are combinational from the address. Writes take effect at the clock edge on which `wr_en` is high.

The six outputs are a combined line followed by one line per source group. Each line is the OR of the masked status over a fixed group of bits. All six are decoded from the registered raw and mask values, so each line follows the register state that the latest clock edge left behind.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While and after reset, the mask and the raw status are zero, all six interrupt outputs are low, and every register reads 0.
- R2: A one on `evt_set[i]` in a cycle sets raw bit i at the next edge. The bit positions are: ring 0, clear-to-send 1, carrier-detect 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10.
- R3: A write to address 0 (data) sets raw bit 5 (transmit) and leaves every other raw bit and the mask unchanged.
- R4: A write to address 4 (clear) clears each raw bit whose position holds a one in `wdata` and keeps the others. Reads of address 4 return 0.
- R5: When a bit is pulsed on `evt_set` in the same cycle that a clear write hits it, the bit ends up set.
- R6: A write to address 1 loads the 11-bit mask from `wdata`, and reads of address 1 return the mask.
- R7: Reads of address 2 return the raw status, and reads of address 3 return the raw status ANDed with the mask.
- R8: Writes to addresses 2 and 3 change neither the raw status nor the mask.
- R9: `irq_ms` is the OR of masked bits 0 to 3, `irq_rx` is masked bit 4, `irq_tx` is masked bit 5, `irq_rt` is masked bit 6, and `irq_err` is the OR of masked bits 7 to 10. Each line reflects the state left by the most recent clock edge.
- R10: `irq_comb` is high exactly when any of the five group lines is high.
- R11: Addresses 5 to 7 read 0, and writes to them change neither the raw status nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 11 | Write data |
| rdata | output | 11 | Read data for `addr`, combinational |
| evt_set | input | 11 | One-cycle set pulses from the event sources |
| irq_comb | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rt | output | 1 | Receive-timeout interrupt line |
| irq_ms | output | 1 | Modem-status interrupt line |
| irq_err | output | 1 | Line-error interrupt line |

## Verification
The assertions check on every cycle that a pulsed bit lands in the raw status, that a clear write leaves no targeted bit set unless a pulse in the same cycle raised it, that a mask write loads the mask, and that writes to the two status views leave the state alone. They also check that the combined line agrees with the group lines, that an all-zero mask keeps every line low, and that the clear register reads 0. The exact grouping of bits onto each line, the read-back values for every raw and mask pattern, and the inertness of the unmapped addresses are shown only by the bench. It sweeps all 2048 raw patterns against several masks and compares the reads and the six lines with values it computes from the bit groups.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int NBITS  = 11;
  localparam int NLINES = 6;
  localparam int ADDR_W = 3;

  localparam int B_RING = 0;
  localparam int B_CTS  = 1;
  localparam int B_DCD  = 2;
  localparam int B_DSR  = 3;
  localparam int B_RX   = 4;
  localparam int B_TX   = 5;
  localparam int B_RT   = 6;
  localparam int B_FRM  = 7;
  localparam int B_PAR  = 8;
  localparam int B_BRK  = 9;
  localparam int B_OVR  = 10;

  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(4);

  typedef enum logic [2:0] {
    LN_COMB = 3'd0,
    LN_RX   = 3'd1,
    LN_TX   = 3'd2,
    LN_RT   = 3'd3,
    LN_MS   = 3'd4,
    LN_ERR  = 3'd5
  } line_e;

  typedef struct packed {
    logic data_wr;
    logic mask_wr;
    logic clear_wr;
  } strobe_t;

  function automatic logic [NBITS-1:0] bitv(input int pos);
    logic [NBITS-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic [NBITS-1:0] line_group(input int k);
    logic [NBITS-1:0] ms, er;
    ms = bitv(B_RING) | bitv(B_CTS) | bitv(B_DCD) | bitv(B_DSR);
    er = bitv(B_FRM) | bitv(B_PAR) | bitv(B_BRK) | bitv(B_OVR);
    case (k)
      int'(LN_COMB): return ms | er | bitv(B_RX) | bitv(B_TX) | bitv(B_RT);
      int'(LN_RX):   return bitv(B_RX);
      int'(LN_TX):   return bitv(B_TX);
      int'(LN_RT):   return bitv(B_RT);
      int'(LN_MS):   return ms;
      int'(LN_ERR):  return er;
      default:       return '0;
    endcase
  endfunction

endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
  import uirq_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBITS-1:0]  raw,
  input  logic [NBITS-1:0]  mask,
  input  logic [NBITS-1:0]  masked,
  output strobe_t           stb,
  output logic [NBITS-1:0]  rdata
);

  always_comb begin
    stb = '0;
    if (wr_en) begin
      unique case (addr)
        A_DATA:  stb.data_wr  = 1'b1;
        A_MASK:  stb.mask_wr  = 1'b1;
        A_CLEAR: stb.clear_wr = 1'b1;
        default: stb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      A_MASK:  rdata = mask;
      A_RAW:   rdata = raw;
      A_MSTAT: rdata = masked;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/uirq_status.sv
module uirq_status
  import uirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_v,
  input  logic [NBITS-1:0] clr_v,
  output logic [NBITS-1:0] raw
);

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        raw[i] <= 1'b0;
      else if (set_v[i])
        raw[i] <= 1'b1;
      else if (clr_v[i])
        raw[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/uirq_route.sv
module uirq_route
  import uirq_pkg::*;
(
  input  logic [NBITS-1:0]  masked,
  output logic [NLINES-1:0] lines
);

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    localparam logic [NBITS-1:0] GRP = line_group(k);
    assign lines[k] = |(masked & GRP);
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBITS-1:0]  wdata,
  output logic [NBITS-1:0]  rdata,
  input  logic [NBITS-1:0]  evt_set,
  output logic              irq_comb,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rt,
  output logic              irq_ms,
  output logic              irq_err
);

  strobe_t           stb;
  logic [NBITS-1:0]  raw_q;
  logic [NBITS-1:0]  mask_q;
  logic [NBITS-1:0]  masked;
  logic [NBITS-1:0]  set_v;
  logic [NBITS-1:0]  clr_v;
  logic [NLINES-1:0] lines;

  assign masked = raw_q & mask_q;
  assign set_v  = evt_set | (stb.data_wr ? bitv(B_TX) : '0);
  assign clr_v  = stb.clear_wr ? wdata : '0;

  uirq_decode u_dec (
    .wr_en  (wr_en),
    .addr   (addr),
    .raw    (raw_q),
    .mask   (mask_q),
    .masked (masked),
    .stb    (stb),
    .rdata  (rdata)
  );

  uirq_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (set_v),
    .clr_v (clr_v),
    .raw   (raw_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '0;
    else if (stb.mask_wr)
      mask_q <= wdata;
  end

  uirq_route u_route (
    .masked (masked),
    .lines  (lines)
  );

  assign irq_comb = lines[LN_COMB];
  assign irq_rx   = lines[LN_RX];
  assign irq_tx   = lines[LN_TX];
  assign irq_rt   = lines[LN_RT];
  assign irq_ms   = lines[LN_MS];
  assign irq_err  = lines[LN_ERR];

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk
  import uirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NBITS-1:0]  wdata,
  input logic [NBITS-1:0]  rdata,
  input logic [NBITS-1:0]  evt_set,
  input logic [NBITS-1:0]  raw,
  input logic [NBITS-1:0]  mask,
  input logic              irq_comb,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              irq_rt,
  input logic              irq_ms,
  input logic              irq_err
);

  a_r2_pulse_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((raw & $past(evt_set)) == $past(evt_set)));

  a_r3_data_sets_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA) |=> raw[B_TX]);

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLEAR) |=> ((raw & $past(wdata) & ~$past(evt_set)) == '0));

  a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CLEAR) |-> (rdata == '0));

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK) |=> (mask == $past(wdata)));

  a_r8_views_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_RAW || addr == A_MSTAT) && evt_set == '0)
      |=> ($stable(raw) && $stable(mask)));

  a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !(irq_rx || irq_tx || irq_rt || irq_ms || irq_err));

  a_r10_combined: assert property (@(posedge clk) disable iff (!rst_n)
    irq_comb == (irq_rx || irq_tx || irq_rt || irq_ms || irq_err));

endmodule

bind uart_irq_ctrl uirq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .evt_set  (evt_set),
  .raw      (raw_q),
  .mask     (mask_q),
  .irq_comb (irq_comb),
  .irq_rx   (irq_rx),
  .irq_tx   (irq_tx),
  .irq_rt   (irq_rt),
  .irq_ms   (irq_ms),
  .irq_err  (irq_err)
);

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [10:0] wdata = '0;
  logic [10:0] rdata;
  logic [10:0] evt_set = '0;
  logic irq_comb, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_set(evt_set), .irq_comb(irq_comb), .irq_rx(irq_rx),
    .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [10:0] d, input logic [10:0] s);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; evt_set = s;
    @(negedge clk);
    wr_en = 1'b0; evt_set = '0; wdata = '0;
  endtask

  task automatic pulse(input logic [10:0] s);
    @(negedge clk);
    evt_set = s;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [10:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  function automatic logic [5:0] exp_lines(input logic [10:0] m);
    logic [5:0] l;
    l[1] = m[4];
    l[2] = m[5];
    l[3] = m[6];
    l[4] = |m[3:0];
    l[5] = |m[10:7];
    l[0] = |m;
    return l;
  endfunction

  function automatic logic [5:0] got_lines();
    return {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_comb};
  endfunction

  initial begin
    logic [10:0] v;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 lines in reset", {26'd0, got_lines()}, 32'd0);
    rd(3'd2, v); check("R1 raw in reset", {21'd0, v}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(3'd1, v); check("R1 mask after reset", {21'd0, v}, 32'd0);
    rd(3'd2, v); check("R1 raw after reset", {21'd0, v}, 32'd0);
    rd(3'd3, v); check("R1 masked after reset", {21'd0, v}, 32'd0);
    check("R1 lines after reset", {26'd0, got_lines()}, 32'd0);

    // R6: mask readback
    bus_wr(3'd1, 11'h5A3, '0);
    rd(3'd1, v); check("R6 mask readback", {21'd0, v}, 32'h5A3);

    // R3: data write sets transmit only
    bus_wr(3'd1, 11'h020, '0);
    bus_wr(3'd0, 11'h7FF, '0);
    rd(3'd2, v); check("R3 data write raw", {21'd0, v}, 32'h020);
    rd(3'd1, v); check("R3 mask kept", {21'd0, v}, 32'h020);
    check("R3 tx line", {31'd0, irq_tx}, 32'd1);

    // R4: clear selected bits, read of clear is zero
    pulse(11'h7FF);
    bus_wr(3'd4, 11'h0F0, '0);
    rd(3'd2, v); check("R4 partial clear", {21'd0, v}, 32'h70F);
    rd(3'd4, v); check("R4 clear reads zero", {21'd0, v}, 32'd0);

    // R5: set wins against clear
    bus_wr(3'd4, 11'h7FF, 11'h081);
    rd(3'd2, v); check("R5 set beats clear", {21'd0, v}, 32'h081);

    // R8: writes to the status views are ignored
    bus_wr(3'd4, 11'h7FF, '0);
    pulse(11'h0F0);
    bus_wr(3'd1, 11'h333, '0);
    bus_wr(3'd2, 11'h000, '0);
    bus_wr(3'd3, 11'h7FF, '0);
    rd(3'd2, v); check("R8 raw unchanged", {21'd0, v}, 32'h0F0);
    rd(3'd1, v); check("R8 mask unchanged", {21'd0, v}, 32'h333);
    check("R8 lines unchanged", {26'd0, got_lines()}, {26'd0, exp_lines(11'h0F0 & 11'h333)});

    // R11: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      bus_wr(3'(a), 11'h7FF, '0);
      rd(3'(a), v); check("R11 unmapped read", {21'd0, v}, 32'd0);
    end
    rd(3'd2, v); check("R11 raw unchanged", {21'd0, v}, 32'h0F0);
    rd(3'd1, v); check("R11 mask unchanged", {21'd0, v}, 32'h333);

    // R2 R7 R9 R10: exhaustive raw sweep with several masks
    for (int r = 0; r < 2048; r++) begin
      logic [10:0] rv;
      rv = 11'(r);
      bus_wr(3'd4, 11'h7FF, '0);
      pulse(rv);
      rd(3'd2, v); check("R2 raw after pulse", {21'd0, v}, {21'd0, rv});
      for (int k = 0; k < 3; k++) begin
        logic [10:0] mv;
        mv = (k == 0) ? 11'h7FF : (k == 1) ? (rv ^ 11'h555) : 11'(r * 37 + 11);
        bus_wr(3'd1, mv, '0);
        rd(3'd3, v); check("R7 masked view", {21'd0, v}, {21'd0, rv & mv});
        check("R9 R10 lines", {26'd0, got_lines()}, {26'd0, exp_lines(rv & mv)});
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule